// File: doc/BRIEF.md
# Multiprocessor Serial Port with Reload-Timer Baud Clock

This block is a full-duplex serial port. Its transmit and receive paths run at the same time. Each path has a one-character holding register in front of (or behind) a shift register. The port has two modes:

- **Asynchronous start-stop mode:** the receiver oversamples the line 16 times per bit and takes a majority vote of three samples near the middle of each bit.
- **Clock-synchronous master mode:** the block drives a shift clock. No start or stop bits are sent.

The baud time base is a tick. It comes either from a built-in 16-bit down-counter with a programmable reload value or from the rising edges of an external clock input. One bit lasts 16 ticks.

Character data moves over two valid/ready streams.

- **Transmit stream:** the holding register accepts a character (`tx_valid && tx_ready`) whenever it is empty. It frees itself as soon as the character moves into the shifter, so the next character can be offered while the current one is on the line.
- **Receive stream:** a character is presented with `rx_valid` and held, unchanged, until `rx_ready` is seen high. The consumer may hold `rx_ready` low for as long as it likes. A character that completes while the output is still held is discarded and flagged as an overrun.

In multiprocessor mode, a bit after the data marks an address frame (1) or a data frame (0). While the sleep input is high, data frames are dropped. Parity, framing and overrun errors are sticky flags that are cleared by a pulse.

Top module: `mp_serial_port`

## Requirements
- R1: After reset, `txd` and `sclk` are 1, `tx_ready` is 1, `rx_valid` is 0 and all three error flags are 0.
- R2: An asynchronous frame is sent as follows: a start bit of 0, then the data LSB first, then the optional extra bit, then a stop bit of 1. Each bit lasts 16 ticks.
- R3: Data length is set by `cfg_len`:
  - Without parity: 0 gives 7 bits, 1 gives 8 bits, 2 or 3 gives 9 bits.
  - With parity (`cfg_par_en`): one bit fewer in each case.
  - The parity bit follows the data. It makes the count of ones even when `cfg_par_odd`=0, and odd when `cfg_par_odd`=1.
  - Parity is not used in multiprocessor or synchronous mode.
- R4: The asynchronous receiver rebuilds the character with the same framing. If the received parity bit disagrees with the data, `err_parity` is set.
- R5: A stop bit received as 0 sets `err_frame`. The character is still delivered.
- R6: A character that completes while `rx_valid` is high and `rx_ready` is low is discarded and sets `err_overrun`. The held character stays unchanged.
- R7: Multiprocessor mode (`cfg_mp_en`):
  - The extra bit carries `tx_addr` on transmit and is reported on `rx_addr` on receive.
  - While `cfg_mp_sleep` is 1, received frames whose extra bit is 0 are dropped without any flag.
- R8: Synchronous transmit:
  - Only the data bits are sent, LSB first.
  - `sclk` falls when each bit is placed on `txd`, and rises in the middle of the bit.
  - `sclk` rests at 1 between characters.
- R9: In synchronous mode, `rxd` is sampled at each rising edge of `sclk`. A character is delivered after the configured number of bits.
- R10: With the internal timer, one tick lasts `cfg_reload`+1 clock cycles. With `cfg_ext_clk_sel`=1, one tick occurs per rising edge of `ext_clk`.
- R11: A low pulse on `rxd` that is shorter than half a bit is rejected as a false start, and no character results.
- R12: The transmit holding register is freed when its character enters the shifter. A second character offered during a frame follows with no idle gap.
- R13: A pulse on `err_clr` returns all three error flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sync | input | 1 | 1 = clock-synchronous master mode |
| cfg_len | input | 2 | Character length code |
| cfg_par_en | input | 1 | Parity enable (asynchronous, non-multiprocessor only) |
| cfg_par_odd | input | 1 | 1 = odd parity |
| cfg_mp_en | input | 1 | Multiprocessor address/data mode |
| cfg_mp_sleep | input | 1 | Drop received data frames while 1 |
| cfg_ext_clk_sel | input | 1 | 1 = tick from ext_clk rising edges |
| cfg_reload | input | 16 | Reload value of the baud timer |
| ext_clk | input | 1 | External tick source |
| tx_valid | input | 1 | Transmit character offered |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_data | input | 9 | Transmit character, LSB first on the line |
| tx_addr | input | 1 | Multiprocessor bit for the transmit character |
| rx_valid | output | 1 | Received character held |
| rx_ready | input | 1 | Consumer takes the held character |
| rx_data | output | 9 | Received character |
| rx_addr | output | 1 | Received multiprocessor bit |
| err_clr | input | 1 | Clear all error flags |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| irq_tx | output | 1 | Transmit holding register empty |
| irq_rx | output | 1 | Character held or error flagged |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| sclk | output | 1 | Shift clock (synchronous mode) |

## Verification
The assertions take these inputs for granted:
- The configuration inputs stay constant while a character is being shifted in either direction.
- `tx_data` and `tx_addr` are steady while `tx_valid` is high.
- `ext_clk` is slow enough that its edges pass the two-stage synchronizer with at least two clocks between edges.

The stimulus keeps within these limits:
- It changes mode, length, parity and timer settings only after both shifters have been idle for a full bit time.
- It drives the transmit stream on falling clock edges and holds `tx_valid` for exactly the handshake cycle.
- It toggles `ext_clk` every three clocks.
- It drives `rxd` in synchronous mode only just after `sclk` falls.

// File: rtl/mpsp_pkg.sv
package mpsp_pkg;

  localparam int DATA_W = 9;
  localparam int NB_W   = 4;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_EXTRA,
    RX_STOP
  } rx_state_e;

  // Data bits per character from the length code; parity steals one bit.
  function automatic logic [NB_W-1:0] char_bits(input logic [1:0] len,
                                                 input logic       par);
    logic [NB_W-1:0] b;
    case (len)
      2'd0:    b = 4'd7;
      2'd1:    b = 4'd8;
      default: b = 4'd9;
    endcase
    if (par) b = b - 4'd1;
    return b;
  endfunction

endpackage

// File: rtl/mpsp_baud.sv
module mpsp_baud #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] reload,
  input  logic          use_ext,
  input  logic          ext_clk,
  output logic          tick
);

  logic [TW-1:0] cnt;
  logic          e1, e2, e3;
  logic          int_tick, ext_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt == '0) begin
      cnt <= reload;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e1 <= 1'b0;
      e2 <= 1'b0;
      e3 <= 1'b0;
    end else begin
      e1 <= ext_clk;
      e2 <= e1;
      e3 <= e2;
    end
  end

  assign int_tick = (cnt == '0);
  assign ext_tick = e2 & ~e3;
  assign tick     = use_ext ? ext_tick : int_tick;

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_ext && tick && reload != '0) |=> (use_ext || !tick)) else $error("tick spacing"); // R10

endmodule

// File: rtl/mpsp_tx.sv
module mpsp_tx
  import mpsp_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int OSR = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            sync_mode,
  input  logic [NB_W-1:0] nbits,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            mp_en,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_data,
  input  logic            in_addr,
  output logic            txd,
  output logic            sclk,
  output logic            samp
);

  localparam int FW = DW + 3;
  localparam int PW = $clog2(OSR);
  localparam int CW = $clog2(FW + 1);

  logic          hold_full, hold_addr;
  logic [DW-1:0] hold_data, dmask;
  logic          active;
  logic [FW-1:0] sh, frm;
  logic [CW-1:0] left, flen;
  logic [PW-1:0] ph;
  logic          pbit, xbit, has_x;
  logic          bit_end, last, load, accept;

  always_comb begin
    for (int i = 0; i < DW; i++) dmask[i] = (NB_W'(i) < nbits);
    pbit  = (^(hold_data & dmask)) ^ par_odd;
    xbit  = mp_en ? hold_addr : pbit;
    has_x = (par_en | mp_en) & ~sync_mode;
    frm   = '1;
    if (sync_mode) begin
      for (int i = 0; i < DW; i++)
        if (NB_W'(i) < nbits) frm[i] = hold_data[i];
      flen = CW'(nbits);
    end else begin
      frm[0] = 1'b0;
      for (int i = 0; i < DW; i++)
        if (NB_W'(i) < nbits) frm[i+1] = hold_data[i];
      for (int j = 1; j < FW; j++)
        if (has_x && (NB_W'(j) == nbits + 4'd1)) frm[j] = xbit;
      flen = CW'(nbits) + CW'(2) + CW'(has_x);
    end
  end

  assign bit_end  = active && tick && (ph == PW'(OSR - 1));
  assign last     = bit_end && (left == CW'(1));
  assign load     = hold_full && tick && (!active || last);
  assign in_ready = !hold_full;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
      hold_addr <= 1'b0;
    end else begin
      hold_full <= accept | (hold_full & ~load);
      if (accept) begin
        hold_data <= in_data;
        hold_addr <= in_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sh     <= '1;
      left   <= '0;
      ph     <= '0;
    end else if (load) begin
      active <= 1'b1;
      sh     <= frm;
      left   <= flen;
      ph     <= '0;
    end else if (last) begin
      active <= 1'b0;
      sh     <= '1;
      ph     <= '0;
    end else if (bit_end) begin
      sh   <= {1'b1, sh[FW-1:1]};
      left <= left - 1'b1;
      ph   <= '0;
    end else if (active && tick) begin
      ph <= ph + 1'b1;
    end
  end

  assign txd  = active ? sh[0] : 1'b1;
  assign sclk = (active && sync_mode) ? ph[PW-1] : 1'b1;
  assign samp = active && sync_mode && tick && (ph == PW'(OSR/2 - 1));

  AST_ASYNC_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !sync_mode) |=> !txd) else $error("start bit"); // R2

  AST_SYNC_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && active && $past(active) && (txd != $past(txd))) |-> !sclk) else $error("sync edge"); // R8

  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !load) |=> (hold_full && $stable(hold_data))) else $error("hold lost"); // R12

endmodule

// File: rtl/mpsp_rx.sv
module mpsp_rx
  import mpsp_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int OSR = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            sync_mode,
  input  logic [NB_W-1:0] nbits,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            mp_en,
  input  logic            mp_sleep,
  input  logic            rxd,
  input  logic            samp,
  input  logic            err_clr,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_data,
  output logic            out_addr,
  output logic            perr,
  output logic            ferr,
  output logic            oerr
);

  localparam int PW = $clog2(OSR);
  localparam int IW = $clog2(DW + 1);

  rx_state_e     st;
  logic          r1, r2, sa, sb, xb, vote, at_mid, has_x;
  logic [PW-1:0] ph;
  logic [IW-1:0] idx;
  logic [DW-1:0] dat, cdata, dmask;
  logic          done_async, done_sync, complete, drop, full, p_bad, f_bad, take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1 <= 1'b1;
      r2 <= 1'b1;
    end else begin
      r1 <= rxd;
      r2 <= r1;
    end
  end

  always_comb begin
    for (int i = 0; i < DW; i++) dmask[i] = (NB_W'(i) < nbits);
    cdata = dat;
    if (sync_mode)
      for (int i = 0; i < DW; i++)
        if (IW'(i) == idx) cdata[i] = r2;
  end

  assign vote       = (sa & sb) | (sa & r2) | (sb & r2);
  assign at_mid     = tick && (ph == PW'(OSR/2 + 1));
  assign has_x      = par_en | mp_en;
  assign done_async = !sync_mode && (st == RX_STOP) && at_mid;
  assign done_sync  = sync_mode && samp && (idx == IW'(nbits - 4'd1));
  assign complete   = done_async | done_sync;
  assign drop       = !sync_mode && mp_en && mp_sleep && !xb;
  assign full       = out_valid && !out_ready;
  assign p_bad      = !sync_mode && par_en && ((^(dat & dmask)) ^ xb ^ par_odd);
  assign f_bad      = !sync_mode && !vote;
  assign take       = complete && !drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= RX_IDLE;
      ph  <= '0;
      sa  <= 1'b1;
      sb  <= 1'b1;
      xb  <= 1'b0;
      idx <= '0;
      dat <= '0;
    end else if (sync_mode) begin
      st <= RX_IDLE;
      xb <= 1'b0;
      if (samp) begin
        if (done_sync) begin
          idx <= '0;
          dat <= '0;
        end else begin
          dat <= cdata;
          idx <= idx + 1'b1;
        end
      end
    end else if (st == RX_IDLE) begin
      idx <= '0;
      dat <= '0;
      if (tick && !r2) begin
        st <= RX_START;
        ph <= PW'(1);
      end
    end else if (tick) begin
      ph <= (ph == PW'(OSR - 1)) ? '0 : ph + 1'b1;
      if (ph == PW'(OSR/2 - 1)) sa <= r2;
      if (ph == PW'(OSR/2))     sb <= r2;
      if (at_mid) begin
        case (st)
          RX_START: st <= vote ? RX_IDLE : RX_DATA;
          RX_DATA: begin
            for (int i = 0; i < DW; i++)
              if (IW'(i) == idx) dat[i] <= vote;
            idx <= idx + 1'b1;
            if (idx == IW'(nbits - 4'd1)) st <= has_x ? RX_EXTRA : RX_STOP;
          end
          RX_EXTRA: begin
            xb <= vote;
            st <= RX_STOP;
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_addr  <= 1'b0;
      perr      <= 1'b0;
      ferr      <= 1'b0;
      oerr      <= 1'b0;
    end else begin
      if (take && !full) begin
        out_valid <= 1'b1;
        out_data  <= cdata;
        out_addr  <= mp_en && !sync_mode && xb;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
      if (take && full)               oerr <= 1'b1;
      else if (err_clr)               oerr <= 1'b0;
      if (take && !full && p_bad)     perr <= 1'b1;
      else if (err_clr)               perr <= 1'b0;
      if (take && !full && f_bad)     ferr <= 1'b1;
      else if (err_clr)               ferr <= 1'b0;
    end
  end

  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))) else $error("rx not held"); // R6

  AST_OVERRUN_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oerr) |-> $past(out_valid && !out_ready)) else $error("spurious overrun"); // R6

  AST_SLEEP_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mp_en && mp_sleep && !sync_mode) && $rose(out_valid)) |-> out_addr) else $error("data frame in sleep"); // R7

endmodule

// File: rtl/mp_serial_port.sv
module mp_serial_port
  import mpsp_pkg::*;
#(
  parameter int TW  = 16,
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sync,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_mp_en,
  input  logic              cfg_mp_sleep,
  input  logic              cfg_ext_clk_sel,
  input  logic [TW-1:0]     cfg_reload,
  input  logic              ext_clk,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_addr,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_addr,
  input  logic              err_clr,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              txd,
  input  logic              rxd,
  output logic              sclk
);

  logic            tick, samp, par_eff, mp_eff;
  logic [NB_W-1:0] nbits;

  assign mp_eff  = cfg_mp_en & ~cfg_sync;
  assign par_eff = cfg_par_en & ~cfg_sync & ~cfg_mp_en;
  assign nbits   = char_bits(cfg_len, par_eff);

  mpsp_baud #(.TW(TW)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (cfg_reload),
    .use_ext (cfg_ext_clk_sel),
    .ext_clk (ext_clk),
    .tick    (tick)
  );

  mpsp_tx #(.DW(DATA_W), .OSR(OSR)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .sync_mode (cfg_sync),
    .nbits     (nbits),
    .par_en    (par_eff),
    .par_odd   (cfg_par_odd),
    .mp_en     (mp_eff),
    .in_valid  (tx_valid),
    .in_ready  (tx_ready),
    .in_data   (tx_data),
    .in_addr   (tx_addr),
    .txd       (txd),
    .sclk      (sclk),
    .samp      (samp)
  );

  mpsp_rx #(.DW(DATA_W), .OSR(OSR)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .sync_mode (cfg_sync),
    .nbits     (nbits),
    .par_en    (par_eff),
    .par_odd   (cfg_par_odd),
    .mp_en     (mp_eff),
    .mp_sleep  (cfg_mp_sleep),
    .rxd       (rxd),
    .samp      (samp),
    .err_clr   (err_clr),
    .out_valid (rx_valid),
    .out_ready (rx_ready),
    .out_data  (rx_data),
    .out_addr  (rx_addr),
    .perr      (err_parity),
    .ferr      (err_frame),
    .oerr      (err_overrun)
  );

  assign irq_tx = tx_ready;
  assign irq_rx = rx_valid | err_parity | err_frame | err_overrun;

endmodule

// File: tb/mp_serial_port_test.sv
module mp_serial_port_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_sync = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_mp_en = 0, cfg_mp_sleep = 0;
  logic cfg_ext_clk_sel = 0, ext_clk = 0, ext_run = 0;
  logic [1:0]  cfg_len = 2'd1;
  logic [15:0] cfg_reload = 16'd1;
  logic tx_valid = 0, tx_addr = 0, rx_ready = 0, err_clr = 0, rxd = 1;
  logic [8:0] tx_data = '0;
  logic tx_ready, rx_valid, rx_addr, err_parity, err_frame, err_overrun, irq_tx, irq_rx, txd, sclk;
  logic [8:0] rx_data;

  int total = 0, bad = 0, bitc = 32;
  logic [8:0] exp_q[$];

  mp_serial_port uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    repeat (3) @(negedge clk);
    if (ext_run) ext_clk = ~ext_clk;
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 act=hung exp=done");
    summary();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic par_of(input logic [8:0] d, input int nb, input logic odd);
    logic p = odd;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return p;
  endfunction

  task automatic push_tx(input logic [8:0] d, input logic a);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1; tx_data = d; tx_addr = a;
    @(negedge clk);
    tx_valid = 0;
  endtask

  // Decode one asynchronous frame from txd; returns bits in line order.
  task automatic mon_async(input int nb, input bit hasx, output logic [11:0] fr);
    fr = '0;
    @(negedge clk);
    while (txd) @(negedge clk);
    repeat (bitc/2) @(negedge clk);
    fr[0] = txd;
    for (int i = 1; i < nb + 2 + int'(hasx); i++) begin
      repeat (bitc) @(negedge clk);
      fr[i] = txd;
    end
  endtask

  function automatic logic [11:0] exp_frame(input logic [8:0] d, input int nb, input bit hasx, input logic x);
    logic [11:0] f = '0;
    for (int i = 0; i < nb; i++) f[i+1] = d[i];
    if (hasx) f[nb+1] = x;
    f[nb+1+int'(hasx)] = 1'b1;
    return f;
  endfunction

  task automatic tx_case(input string req, input logic [8:0] d, input int nb, input bit hasx, input logic x, input logic a);
    logic [11:0] got, e;
    e = exp_frame(d, nb, hasx, x);
    fork
      push_tx(d, a);
      mon_async(nb, hasx, got);
    join
    chk(got == e, req, got, e);
    repeat (bitc) @(negedge clk);
  endtask

  task automatic drive_async(input logic [8:0] d, input int nb, input bit hasx, input logic x, input logic stp);
    @(negedge clk); rxd = 0;
    repeat (bitc) @(negedge clk);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; repeat (bitc) @(negedge clk); end
    if (hasx) begin rxd = x; repeat (bitc) @(negedge clk); end
    rxd = stp; repeat (bitc) @(negedge clk);
    rxd = 1; repeat (4) @(negedge clk);
  endtask

  task automatic read_rx(input string req, input logic [8:0] ed, input logic ea);
    @(negedge clk);
    chk(rx_valid == 1'b1, req, rx_valid, 1);
    chk(rx_data == ed && rx_addr == ea, req, {rx_addr, rx_data}, {ea, ed});
    rx_ready = 1; @(negedge clk); rx_ready = 0;
  endtask

  task automatic meas_low(output int n);
    n = 0;
    @(negedge clk);
    while (txd) @(negedge clk);
    while (!txd) begin n++; @(negedge clk); end
  endtask

  task automatic mon_sync(input int nb, output logic [8:0] got);
    logic prev = sclk;
    got = '0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      while (!(prev == 0 && sclk == 1)) begin prev = sclk; @(negedge clk); end
      prev = sclk;
      got[i] = txd;
    end
  endtask

  task automatic drv_sync(input int nb, input logic [8:0] d);
    logic prev = sclk;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      while (!(prev == 1 && sclk == 0)) begin prev = sclk; @(negedge clk); end
      prev = sclk;
      rxd = d[i];
    end
  endtask

  initial begin
    int n;
    logic [8:0] sg;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(txd && sclk && tx_ready && !rx_valid, "R1", {txd, sclk, tx_ready, rx_valid}, 4'b1110);
    chk({err_parity, err_frame, err_overrun} == 3'b000, "R1", {err_parity, err_frame, err_overrun}, 0);

    // R2 8-bit frame, no parity
    tx_case("R2", 9'h0A5, 8, 0, 0, 0);
    // R3 length table and parity
    cfg_len = 2'd0; tx_case("R3 len7", 9'h055, 7, 0, 0, 0);
    cfg_len = 2'd2; tx_case("R3 len9", 9'h1C3, 9, 0, 0, 0);
    cfg_len = 2'd1; cfg_par_en = 1; cfg_par_odd = 0;
    tx_case("R3 even", 9'h05B, 7, 1, par_of(9'h05B, 7, 0), 0);
    cfg_len = 2'd0; cfg_par_odd = 1;
    tx_case("R3 odd", 9'h02B, 6, 1, par_of(9'h02B, 6, 1), 0);

    // R12 double buffering, back-to-back 9-bit frames
    cfg_par_en = 0; cfg_par_odd = 0; cfg_len = 2'd2;
    begin
      logic [11:0] g1, g2;
      fork
        begin mon_async(9, 0, g1); mon_async(9, 0, g2); end
        begin
          push_tx(9'h12D, 0);
          repeat (4) @(negedge clk);
          chk(tx_ready == 1'b1, "R12 ready", tx_ready, 1);
          push_tx(9'h0F0, 0);
        end
      join
      chk(g1 == exp_frame(9'h12D, 9, 0, 0), "R12 first", g1, exp_frame(9'h12D, 9, 0, 0));
      chk(g2 == exp_frame(9'h0F0, 9, 0, 0), "R12 second", g2, exp_frame(9'h0F0, 9, 0, 0));
      repeat (bitc) @(negedge clk);
    end

    // R10 tick period from reload and from ext_clk
    cfg_len = 2'd1;
    fork push_tx(9'h0FE, 0); meas_low(n); join
    chk(n >= 63 && n <= 65, "R10 reload1", n, 64);
    repeat (bitc * 10) @(negedge clk);
    cfg_reload = 16'd3; bitc = 64;
    fork push_tx(9'h0FE, 0); meas_low(n); join
    chk(n >= 127 && n <= 129, "R10 reload3", n, 128);
    repeat (bitc * 10) @(negedge clk);
    cfg_ext_clk_sel = 1; ext_run = 1; bitc = 96;
    fork push_tx(9'h0FE, 0); meas_low(n); join
    chk(n >= 190 && n <= 194, "R10 ext", n, 192);
    repeat (bitc * 10) @(negedge clk);
    cfg_ext_clk_sel = 0; ext_run = 0; cfg_reload = 16'd1; bitc = 32;
    repeat (bitc) @(negedge clk);

    // R4 receive, parity good and bad
    exp_q.push_back(9'h03C);
    drive_async(9'h03C, 8, 0, 0, 1);
    read_rx("R4 8N1", exp_q.pop_front(), 0);
    cfg_par_en = 1; cfg_len = 2'd1;
    drive_async(9'h035, 7, 1, par_of(9'h035, 7, 0), 1);
    read_rx("R4 par ok", 9'h035, 0);
    chk(err_parity == 0, "R4 no perr", err_parity, 0);
    drive_async(9'h035, 7, 1, ~par_of(9'h035, 7, 0), 1);
    read_rx("R4 par bad", 9'h035, 0);
    chk(err_parity == 1, "R4 perr", err_parity, 1);
    cfg_par_en = 0;

    // R5 framing error
    drive_async(9'h081, 8, 0, 0, 0);
    repeat (bitc) @(negedge clk);
    read_rx("R5 data", 9'h081, 0);
    chk(err_frame == 1, "R5 ferr", err_frame, 1);

    // R13 clear
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    chk({err_parity, err_frame, err_overrun} == 3'b000, "R13", {err_parity, err_frame, err_overrun}, 0);

    // R6 overrun
    drive_async(9'h011, 8, 0, 0, 1);
    drive_async(9'h022, 8, 0, 0, 1);
    chk(err_overrun == 1, "R6 flag", err_overrun, 1);
    read_rx("R6 kept", 9'h011, 0);
    @(negedge clk);
    chk(rx_valid == 0, "R6 discarded", rx_valid, 0);
    err_clr = 1; @(negedge clk); err_clr = 0;

    // R11 false start
    @(negedge clk); rxd = 0; repeat (8) @(negedge clk); rxd = 1;
    repeat (bitc * 12) @(negedge clk);
    chk(rx_valid == 0 && err_frame == 0, "R11", {rx_valid, err_frame}, 0);
    drive_async(9'h0C6, 8, 0, 0, 1);
    read_rx("R11 after", 9'h0C6, 0);

    // R7 multiprocessor
    cfg_mp_en = 1; cfg_mp_sleep = 1;
    tx_case("R7 tx addr", 9'h042, 8, 1, 1, 1);
    drive_async(9'h077, 8, 1, 0, 1);
    repeat (bitc) @(negedge clk);
    chk(rx_valid == 0, "R7 dropped", rx_valid, 0);
    drive_async(9'h05A, 8, 1, 1, 1);
    read_rx("R7 addr", 9'h05A, 1);
    cfg_mp_sleep = 0;
    drive_async(9'h077, 8, 1, 0, 1);
    read_rx("R7 data", 9'h077, 0);
    cfg_mp_en = 0;

    // R8 and R9 synchronous mode
    repeat (bitc) @(negedge clk);
    cfg_sync = 1;
    fork
      push_tx(9'h096, 0);
      mon_sync(8, sg);
      drv_sync(8, 9'h04B);
    join
    chk(sg == 9'h096, "R8 sync tx", sg, 9'h096);
    repeat (bitc) @(negedge clk);
    chk(sclk == 1, "R8 sclk idle", sclk, 1);
    read_rx("R9 sync rx", 9'h04B, 0);
    rxd = 1; cfg_sync = 0;

    summary();
  end

endmodule